// File: doc/BRIEF.md
# Accelerator configuration and status register bank

This block is the host-facing register bank of a matrix-multiply accelerator. A host CPU reaches it over a simple APB-style bus that has zero wait states. Through it the host programs one layer computation:

- the sizes of the input and weight matrices;
- a set of per-layer option flags;
- a quantization shift and an activation choice;
- the source and destination memory addresses.

Every stored field is driven continuously toward the compute engine.

Writing a one to the launch word sends a single-cycle start pulse to the engine. When the engine finishes, it pulses a done input and presents a 2-bit status. The bank latches the status as an exit code and raises a completion interrupt. The interrupt stays high until software clears it by writing a one. Two constant identification words let software recognise the accelerator. Any location outside the 0x48-byte window reads as zero.

Top module: `npu_cfg_regs`

## Requirements
- R1: After reset, all read/write fields, start_o, irq_o and the exit code are 0.
- R2: Word 0x00 always reads 0x0000B00B and word 0x04 always reads 0x00000100. Writes to them have no effect.
- R3: Words 0x08, 0x0C, 0x10 and 0x14 hold input rows, input columns, weight rows and weight columns, and 0x2C holds the shift amount. Each is an 8-bit read/write field in bits 7:0, drives its output port, and reads 0 in bits 31:8.
- R4: Bit 0 of each of these words is a read/write flag driving its port: 0x18 reuse input, 0x1C reuse weights, 0x20 save output, 0x24 bias enable, 0x28 summation enable, and 0x30 activation (1 = ReLU, 0 = none). Bits 31:1 read 0.
- R5: Words 0x34 (source address) and 0x38 (result address) are full 32-bit read/write registers driving src_addr_o and dst_addr_o.
- R6: A write to 0x3C with bit 0 set makes start_o high for exactly the one cycle after the write's access phase. A write there with bit 0 clear gives no pulse. Reads of 0x3C return 0.
- R7: A done_i pulse sets the interrupt bit, which reads at bit 0 of 0x40. irq_o equals that bit, and the bit holds until it is cleared.
- R8: Writing 1 to bit 0 of 0x40 clears the interrupt, and writing 0 leaves it unchanged. If done_i and a clear fall in the same cycle, the bit ends set.
- R9: On a done_i pulse, bits 1:0 of 0x44 capture status_i (00 unused, 01 success, 10 memory error, 11 CPU error). The value holds until the next done_i, and writes to 0x44 are ignored.
- R10: Reads of offsets 0x48 and above return 0. Writes there change no register.
- R11: A write commits only when psel_i, penable_i and pwrite_i are all high. A setup-phase cycle alone has no effect. Address bits 1:0 are ignored. prdata_o is 0 unless psel_i is high with pwrite_i low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | Bus select |
| penable_i | input | 1 | Bus access phase |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | ADDR_W | Byte address |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data |
| in_rows_o | output | DIM_W | Input matrix rows |
| in_cols_o | output | DIM_W | Input matrix columns |
| wt_rows_o | output | DIM_W | Weight matrix rows |
| wt_cols_o | output | DIM_W | Weight matrix columns |
| reuse_in_o | output | 1 | Use previous results as input |
| reuse_wt_o | output | 1 | Reuse previous weights |
| save_out_o | output | 1 | Save layer output |
| bias_en_o | output | 1 | Add bias |
| sum_en_o | output | 1 | Use summation values |
| act_relu_o | output | 1 | Apply ReLU |
| shift_o | output | SHIFT_W | Quantization shift amount |
| src_addr_o | output | MADDR_W | Source base address |
| dst_addr_o | output | MADDR_W | Result address |
| start_o | output | 1 | Single-cycle launch pulse |
| done_i | input | 1 | Engine finish pulse |
| status_i | input | 2 | Engine status code |
| irq_o | output | 1 | Completion interrupt level |

## Verification
The bench builds the block with its defaults: ADDR_W = 8, DIM_W = 8, SHIFT_W = 8 and MADDR_W = 32. With 8 address bits, the unmapped offsets from 0x48 up to 0xFC are within reach, so reads and writes there can be exercised. The 8-bit field width lets all-ones writes show that bits 31:8 of the dimension and shift words read zero. A full 32-bit address width exercises every bit of the two address registers. The bench also produces a done pulse and an interrupt clear in the same cycle, and it uses each exit-code value.

// File: rtl/npu_cfg_pkg.sv
package npu_cfg_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned NUM_WORDS = 18;
  localparam int unsigned NUM_DIMS  = 4;
  localparam int unsigned NUM_FLAGS = 6;

  // word indices (byte offset / 4); order is the bus map
  localparam int unsigned W_ARCH  = 0;
  localparam int unsigned W_IMP   = 1;
  localparam int unsigned W_DIM0  = 2;
  localparam int unsigned W_FLAG0 = 6;
  localparam int unsigned W_SHIFT = 11;
  localparam int unsigned W_ACT   = 12;
  localparam int unsigned W_SRC   = 13;
  localparam int unsigned W_DST   = 14;
  localparam int unsigned W_START = 15;
  localparam int unsigned W_IRQ   = 16;
  localparam int unsigned W_EXIT  = 17;

  localparam logic [DATA_W-1:0] ARCH_ID = 32'h0000_B00B;
  localparam logic [DATA_W-1:0] IMP_ID  = 32'h0000_0100;

  typedef enum logic [1:0] {
    EXIT_UNUSED  = 2'b00,
    EXIT_OK      = 2'b01,
    EXIT_MEM_ERR = 2'b10,
    EXIT_CPU_ERR = 2'b11
  } exit_e;

  // flags 0..4 are contiguous, flag 5 (activation) sits after the shift word
  function automatic int unsigned flag_word(int unsigned i);
    return (i < 5) ? (W_FLAG0 + i) : W_ACT;
  endfunction
endpackage

// File: rtl/npu_cfg_decode.sv
module npu_cfg_decode
  import npu_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic                   psel_i,
  input  logic                   penable_i,
  input  logic                   pwrite_i,
  input  logic [ADDR_W-1:0]      paddr_i,
  output logic [NUM_WORDS-1:0]   wr_sel_o,
  output logic                   rd_en_o,
  output logic [ADDR_W-3:0]      idx_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic wr_en;

  assign idx_o   = paddr_i[ADDR_W-1:2];
  assign wr_en   = psel_i & penable_i & pwrite_i;
  assign rd_en_o = psel_i & ~pwrite_i;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_sel
    assign wr_sel_o[w] = wr_en && (idx_o == IDX_W'(w));
  end
endmodule

// File: rtl/npu_cfg_store.sv
module npu_cfg_store
  import npu_cfg_pkg::*;
#(
  parameter int unsigned DIM_W   = 8,
  parameter int unsigned SHIFT_W = 8,
  parameter int unsigned MADDR_W = 32
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_WORDS-1:0]             wr_sel_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [NUM_DIMS-1:0][DIM_W-1:0]   dims_o,
  output logic [NUM_FLAGS-1:0]             flags_o,
  output logic [SHIFT_W-1:0]               shift_o,
  output logic [MADDR_W-1:0]               src_o,
  output logic [MADDR_W-1:0]               dst_o
);
  for (genvar d = 0; d < NUM_DIMS; d++) begin : g_dim
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   dims_o[d] <= '0;
      else if (wr_sel_i[W_DIM0 + d]) dims_o[d] <= wdata_i[DIM_W-1:0];
    end
  end

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    localparam int unsigned FW = flag_word(f);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           flags_o[f] <= 1'b0;
      else if (wr_sel_i[FW]) flags_o[f] <= wdata_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_o <= '0;
      src_o   <= '0;
      dst_o   <= '0;
    end else begin
      if (wr_sel_i[W_SHIFT]) shift_o <= wdata_i[SHIFT_W-1:0];
      if (wr_sel_i[W_SRC])   src_o   <= wdata_i[MADDR_W-1:0];
      if (wr_sel_i[W_DST])   dst_o   <= wdata_i[MADDR_W-1:0];
    end
  end
endmodule

// File: rtl/npu_cfg_event.sv
module npu_cfg_event
  import npu_cfg_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_wr_i,
  input  logic        irq_wr_i,
  input  logic        wbit0_i,
  input  logic        done_i,
  input  logic [1:0]  status_i,
  output logic        start_o,
  output logic        irq_o,
  output exit_e       exit_o
);
  logic irq_clr;

  assign irq_clr = irq_wr_i & wbit0_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o <= 1'b0;
      irq_o   <= 1'b0;
      exit_o  <= EXIT_UNUSED;
    end else begin
      start_o <= start_wr_i & wbit0_i;
      // set dominates clear
      irq_o   <= done_i | (irq_o & ~irq_clr);
      if (done_i) exit_o <= exit_e'(status_i);
    end
  end
endmodule

// File: rtl/npu_cfg_regs.sv
module npu_cfg_regs
  import npu_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DIM_W   = 8,
  parameter int unsigned SHIFT_W = 8,
  parameter int unsigned MADDR_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 psel_i,
  input  logic                 penable_i,
  input  logic                 pwrite_i,
  input  logic [ADDR_W-1:0]    paddr_i,
  input  logic [31:0]          pwdata_i,
  output logic [31:0]          prdata_o,
  output logic [DIM_W-1:0]     in_rows_o,
  output logic [DIM_W-1:0]     in_cols_o,
  output logic [DIM_W-1:0]     wt_rows_o,
  output logic [DIM_W-1:0]     wt_cols_o,
  output logic                 reuse_in_o,
  output logic                 reuse_wt_o,
  output logic                 save_out_o,
  output logic                 bias_en_o,
  output logic                 sum_en_o,
  output logic                 act_relu_o,
  output logic [SHIFT_W-1:0]   shift_o,
  output logic [MADDR_W-1:0]   src_addr_o,
  output logic [MADDR_W-1:0]   dst_addr_o,
  output logic                 start_o,
  input  logic                 done_i,
  input  logic [1:0]           status_i,
  output logic                 irq_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [NUM_WORDS-1:0]           wr_sel;
  logic                           rd_en;
  logic [IDX_W-1:0]               idx;
  logic [NUM_DIMS-1:0][DIM_W-1:0] dims;
  logic [NUM_FLAGS-1:0]           flags;
  exit_e                          exit_code;
  logic [DATA_W-1:0]              rd_words [NUM_WORDS];

  npu_cfg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .psel_i    (psel_i),
    .penable_i (penable_i),
    .pwrite_i  (pwrite_i),
    .paddr_i   (paddr_i),
    .wr_sel_o  (wr_sel),
    .rd_en_o   (rd_en),
    .idx_o     (idx)
  );

  npu_cfg_store #(
    .DIM_W   (DIM_W),
    .SHIFT_W (SHIFT_W),
    .MADDR_W (MADDR_W)
  ) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_sel_i (wr_sel),
    .wdata_i  (pwdata_i),
    .dims_o   (dims),
    .flags_o  (flags),
    .shift_o  (shift_o),
    .src_o    (src_addr_o),
    .dst_o    (dst_addr_o)
  );

  npu_cfg_event u_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_wr_i (wr_sel[W_START]),
    .irq_wr_i   (wr_sel[W_IRQ]),
    .wbit0_i    (pwdata_i[0]),
    .done_i     (done_i),
    .status_i   (status_i),
    .start_o    (start_o),
    .irq_o      (irq_o),
    .exit_o     (exit_code)
  );

  assign in_rows_o  = dims[0];
  assign in_cols_o  = dims[1];
  assign wt_rows_o  = dims[2];
  assign wt_cols_o  = dims[3];
  assign reuse_in_o = flags[0];
  assign reuse_wt_o = flags[1];
  assign save_out_o = flags[2];
  assign bias_en_o  = flags[3];
  assign sum_en_o   = flags[4];
  assign act_relu_o = flags[5];

  always_comb begin
    for (int w = 0; w < NUM_WORDS; w++) rd_words[w] = '0;
    rd_words[W_ARCH]  = ARCH_ID;
    rd_words[W_IMP]   = IMP_ID;
    for (int d = 0; d < NUM_DIMS; d++)
      rd_words[W_DIM0 + d] = DATA_W'(dims[d]);
    for (int f = 0; f < NUM_FLAGS; f++)
      rd_words[flag_word(f)] = DATA_W'(flags[f]);
    rd_words[W_SHIFT] = DATA_W'(shift_o);
    rd_words[W_SRC]   = DATA_W'(src_addr_o);
    rd_words[W_DST]   = DATA_W'(dst_addr_o);
    rd_words[W_IRQ]   = DATA_W'(irq_o);
    rd_words[W_EXIT]  = DATA_W'(exit_code);
  end

  always_comb begin
    prdata_o = '0;
    if (rd_en) begin
      for (int w = 0; w < NUM_WORDS; w++)
        if (idx == IDX_W'(w)) prdata_o = rd_words[w];
    end
  end
endmodule

// File: rtl/npu_cfg_regs_chk.sv
module npu_cfg_regs_chk
  import npu_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DIM_W   = 8,
  parameter int unsigned SHIFT_W = 8,
  parameter int unsigned MADDR_W = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                psel_i,
  input logic                penable_i,
  input logic                pwrite_i,
  input logic [ADDR_W-1:0]   paddr_i,
  input logic [31:0]         pwdata_i,
  input logic [31:0]         prdata_o,
  input logic [DIM_W-1:0]    in_rows_o,
  input logic [MADDR_W-1:0]  src_addr_o,
  input logic                start_o,
  input logic                done_i,
  input logic                irq_o
);
  logic [ADDR_W-3:0] widx;
  logic              acc_wr;
  logic              rd;

  assign widx   = paddr_i[ADDR_W-1:2];
  assign acc_wr = psel_i && penable_i && pwrite_i;
  assign rd     = psel_i && !pwrite_i;

  p_launch_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_wr && widx == W_START && pwdata_i[0]) |=> start_o);

  p_no_spurious_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_wr && widx == W_START && pwdata_i[0]) |=> !start_o);

  p_launch_reads_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && widx == W_START) |-> prdata_o == 32'h0);

  p_irq_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> irq_o);

  p_irq_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(acc_wr && widx == W_IRQ && pwdata_i[0])) |=> irq_o);

  p_irq_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_wr && widx == W_IRQ && pwdata_i[0] && !done_i) |=> !irq_o);

  p_arch_id_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && widx == W_ARCH) |-> prdata_o == ARCH_ID);

  p_unmapped_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && widx >= NUM_WORDS) |-> prdata_o == 32'h0);

  p_idle_bus_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |-> prdata_o == 32'h0);

  p_cfg_stable_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_wr |=> ($stable(in_rows_o) && $stable(src_addr_o)));
endmodule

bind npu_cfg_regs npu_cfg_regs_chk #(
  .ADDR_W  (ADDR_W),
  .DIM_W   (DIM_W),
  .SHIFT_W (SHIFT_W),
  .MADDR_W (MADDR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .psel_i     (psel_i),
  .penable_i  (penable_i),
  .pwrite_i   (pwrite_i),
  .paddr_i    (paddr_i),
  .pwdata_i   (pwdata_i),
  .prdata_o   (prdata_o),
  .in_rows_o  (in_rows_o),
  .src_addr_o (src_addr_o),
  .start_o    (start_o),
  .done_i     (done_i),
  .irq_o      (irq_o)
);

// File: tb/npu_cfg_regs_test.sv
`timescale 1ns/1ps
module npu_cfg_regs_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        psel_i = 1'b0, penable_i = 1'b0, pwrite_i = 1'b0;
  logic [7:0]  paddr_i = '0;
  logic [31:0] pwdata_i = '0;
  logic [31:0] prdata_o;
  logic [7:0]  in_rows_o, in_cols_o, wt_rows_o, wt_cols_o, shift_o;
  logic        reuse_in_o, reuse_wt_o, save_out_o, bias_en_o, sum_en_o, act_relu_o;
  logic [31:0] src_addr_o, dst_addr_o;
  logic        start_o, irq_o;
  logic        done_i = 1'b0;
  logic [1:0]  status_i = '0;

  int n_cmp = 0, n_bad = 0;
  bit ended = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk_i = ~clk_i;

  npu_cfg_regs uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .psel_i(psel_i), .penable_i(penable_i),
    .pwrite_i(pwrite_i), .paddr_i(paddr_i), .pwdata_i(pwdata_i), .prdata_o(prdata_o),
    .in_rows_o(in_rows_o), .in_cols_o(in_cols_o), .wt_rows_o(wt_rows_o),
    .wt_cols_o(wt_cols_o), .reuse_in_o(reuse_in_o), .reuse_wt_o(reuse_wt_o),
    .save_out_o(save_out_o), .bias_en_o(bias_en_o), .sum_en_o(sum_en_o),
    .act_relu_o(act_relu_o), .shift_o(shift_o), .src_addr_o(src_addr_o),
    .dst_addr_o(dst_addr_o), .start_o(start_o), .done_i(done_i),
    .status_i(status_i), .irq_o(irq_o)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compares read data in the access phase against the scoreboard
  initial forever begin
    @(negedge clk_i); #1;
    if (psel_i && penable_i && !pwrite_i) begin
      if (exp_q.size() == 0) check(prdata_o, 32'hxxxx_xxxx, "scoreboard empty");
      else check(prdata_o, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i); psel_i = 1; penable_i = 0; pwrite_i = 1; paddr_i = a; pwdata_i = d;
    @(negedge clk_i); penable_i = 1;
    @(negedge clk_i); psel_i = 0; penable_i = 0; pwrite_i = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk_i); psel_i = 1; penable_i = 0; pwrite_i = 0; paddr_i = a;
    @(negedge clk_i); penable_i = 1;
    @(negedge clk_i); psel_i = 0; penable_i = 0;
  endtask

  task automatic finish_pulse(input logic [1:0] st);
    @(negedge clk_i); done_i = 1; status_i = st;
    @(negedge clk_i); done_i = 0; status_i = 2'b00;
  endtask

  initial begin
    #150000;
    if (!ended) begin
      ended = 1; n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #9 rst_ni = 1;
    // R1 reset state
    @(negedge clk_i);
    check({24'd0, in_rows_o}, 0, "R1 in_rows");
    check({26'd0, reuse_in_o, reuse_wt_o, save_out_o, bias_en_o, sum_en_o, act_relu_o}, 0, "R1 flags");
    check(src_addr_o | dst_addr_o, 0, "R1 addrs");
    check({30'd0, start_o, irq_o}, 0, "R1 start/irq");
    bus_rd(8'h44, 0, "R1 exit code");
    bus_rd(8'h2C, 0, "R1 shift");
    // R2 identification
    bus_rd(8'h00, 32'h0000B00B, "R2 arch");
    bus_rd(8'h04, 32'h00000100, "R2 imp");
    bus_wr(8'h00, 32'h12345678);
    bus_rd(8'h00, 32'h0000B00B, "R2 arch after write");
    // R3 dimensions and shift
    bus_wr(8'h08, 32'hFFFF_FFFF);
    bus_wr(8'h0C, 32'h0000_0012);
    bus_wr(8'h10, 32'hABCD_0034);
    bus_wr(8'h14, 32'h0000_0056);
    bus_wr(8'h2C, 32'h0000_1F07);
    check({in_rows_o, in_cols_o, wt_rows_o, wt_cols_o}, 32'hFF123456, "R3 dim ports");
    check({24'd0, shift_o}, 32'h07, "R3 shift port");
    bus_rd(8'h08, 32'hFF, "R3 rows upper zero");
    bus_rd(8'h10, 32'h34, "R3 wt rows");
    bus_rd(8'h2C, 32'h07, "R3 shift read");
    // R4 flags
    bus_wr(8'h18, 32'hFFFF_FFFF);
    bus_wr(8'h20, 32'h1);
    bus_wr(8'h28, 32'h1);
    bus_wr(8'h30, 32'h3);
    check({26'd0, reuse_in_o, reuse_wt_o, save_out_o, bias_en_o, sum_en_o, act_relu_o},
          32'b101011, "R4 flag ports");
    bus_rd(8'h18, 32'h1, "R4 reuse in upper zero");
    bus_rd(8'h1C, 32'h0, "R4 reuse wt");
    bus_rd(8'h30, 32'h1, "R4 relu");
    bus_wr(8'h30, 32'h0);
    check({31'd0, act_relu_o}, 0, "R4 relu off");
    // R5 addresses
    bus_wr(8'h34, 32'hDEAD_BEEF);
    bus_wr(8'h38, 32'h8000_0001);
    check(src_addr_o, 32'hDEADBEEF, "R5 src port");
    check(dst_addr_o, 32'h80000001, "R5 dst port");
    bus_rd(8'h34, 32'hDEADBEEF, "R5 src read");
    bus_rd(8'h38, 32'h80000001, "R5 dst read");
    // R6 start strobe
    bus_wr(8'h3C, 32'h1);
    check({31'd0, start_o}, 1, "R6 pulse cycle");
    @(negedge clk_i);
    check({31'd0, start_o}, 0, "R6 pulse single");
    bus_wr(8'h3C, 32'hFFFF_FFFE);
    check({31'd0, start_o}, 0, "R6 bit0 clear no pulse");
    bus_rd(8'h3C, 0, "R6 read zero");
    // R7/R9 finish
    finish_pulse(2'b10);
    check({31'd0, irq_o}, 1, "R7 irq set");
    repeat (3) @(negedge clk_i);
    check({31'd0, irq_o}, 1, "R7 irq holds");
    bus_rd(8'h40, 32'h1, "R7 irq read");
    bus_rd(8'h44, 32'h2, "R9 mem err");
    bus_wr(8'h44, 32'h3);
    bus_rd(8'h44, 32'h2, "R9 write ignored");
    // R8 clears
    bus_wr(8'h40, 32'h0);
    check({31'd0, irq_o}, 1, "R8 write 0 keeps");
    bus_wr(8'h40, 32'h1);
    check({31'd0, irq_o}, 0, "R8 clear");
    bus_rd(8'h40, 32'h0, "R8 read cleared");
    // R8 simultaneous set and clear
    finish_pulse(2'b01);
    @(negedge clk_i); psel_i = 1; pwrite_i = 1; paddr_i = 8'h40; pwdata_i = 1;
    @(negedge clk_i); penable_i = 1; done_i = 1; status_i = 2'b11;
    @(negedge clk_i); psel_i = 0; penable_i = 0; pwrite_i = 0; done_i = 0; status_i = 0;
    check({31'd0, irq_o}, 1, "R8 set wins");
    bus_rd(8'h44, 32'h3, "R9 cpu err");
    finish_pulse(2'b00);
    bus_rd(8'h44, 32'h0, "R9 unused");
    // R10 unmapped
    bus_rd(8'h48, 0, "R10 0x48");
    bus_rd(8'hFC, 0, "R10 0xFC");
    bus_wr(8'h48, 32'hFFFF_FFFF);
    bus_wr(8'h88, 32'hFFFF_FFFF); // would alias 0x08 if upper address bits were dropped
    check({24'd0, in_rows_o}, 32'hFF, "R10 rows untouched");
    check({24'd0, in_cols_o}, 32'h12, "R10 cols untouched");
    // R11 setup-only cycle, low address bits, idle read data
    @(negedge clk_i); psel_i = 1; penable_i = 0; pwrite_i = 1; paddr_i = 8'h0C; pwdata_i = 32'h99;
    @(negedge clk_i); psel_i = 0; pwrite_i = 0;
    check({24'd0, in_cols_o}, 32'h12, "R11 setup only");
    bus_wr(8'h0F, 32'h77);
    check({24'd0, in_cols_o}, 32'h77, "R11 low bits ignored");
    bus_rd(8'h0D, 32'h77, "R11 low bits read");
    @(negedge clk_i); #1;
    check(prdata_o, 0, "R11 idle zero");
    repeat (2) @(negedge clk_i);
    if (exp_q.size() != 0) check(exp_q.size(), 0, "scoreboard drained");
    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule